// File: doc/BRIEF.md
# Conditional Branch and Next-PC Unit

This block settles where an 8-bit processor goes after a control-transfer opcode. It covers short relative jumps, the decrement-and-branch loop opcode, absolute jumps (including the jump through the HL pair), subroutine calls, returns and the eight fixed-vector restarts. Taken and not-taken outcomes are handled, and the condition is tested against four flags of the flag register.

The sequencer pulses `start` with the opcode and its operands. The program counter presented with the opcode already points past the opcode byte. The block answers with a one-cycle `done` pulse carrying the next program counter and a `taken` indication. When a return address has to be saved, the block asks the stack logic with `pushReq` and waits for `pushAck`. When a return address has to be recovered, it raises `popReq` and takes the popped value at `popAck`. For the decrement-and-branch opcode it also returns the decremented B register value with a write strobe.

Flag positions used for conditions are sign bit 7, zero bit 6, parity bit 2 and carry bit 0. A condition index of 0 to 7 means, in order: zero clear, zero set, carry clear, carry set, parity clear, parity set, sign clear, sign set.

Top module: `nextpc_unit`

## Requirements
- R1: After reset, `nextPc` is 0, `done`, `taken`, `pushReq`, `popReq` and `bWrite` are 0, and `ready` is 1.
- R2: Opcode 0x18 always jumps. `nextPc` is `pcIn`+1 plus the sign-extended `disp`. `done` and the result appear in the cycle after the `start` edge.
- R3: Opcodes 0x20, 0x28, 0x30 and 0x38 jump relative on condition index 0, 1, 2 and 3 respectively. When the condition fails, `nextPc` is `pcIn`+1 and `taken` is 0.
- R4: Opcode 0x10 returns `bOut` = `bIn`−1 with `bWrite` high in the `done` cycle. It branches relative only when that new value is nonzero, so `bIn`=0 wraps to 0xFF and branches. When it does not branch, `nextPc` is `pcIn`+1.
- R5: Absolute jumps 11ccc010 take `target` when condition index ccc (opcode bits 5:3) holds, and give `pcIn`+2 otherwise. Opcode 0xC3 always takes `target`.
- R6: Calls 0xCD and 11ccc100 (when the condition holds) raise `pushReq` with `pushData` = `pcIn`+2. Both are held until `pushAck`, after which `done` gives `nextPc` = `target`. A failed call gives `pcIn`+2 with no push.
- R7: Returns 0xC9 and 11ccc000 (when the condition holds) raise `popReq` until `popAck`, and `nextPc` is `popData` sampled at that edge. A failed return gives `pcIn` with no pop. Push and pop are never requested together.
- R8: Restarts 11vvv111 push `pcIn` and give `nextPc` = vvv×8, which is in the range 0x00 to 0x38.
- R9: Opcode 0xE9 gives `nextPc` = `hlIn` with `taken` = 1.
- R10: Any other opcode gives `nextPc` = `pcIn`, `taken` = 0, no push, no pop and no `bWrite`.
- R11: `ready` is low from the `start` edge until the cycle after `done`. A `start` while not ready is ignored and changes neither the pending request nor the result.
- R12: `done` lasts exactly one cycle. In that cycle `taken` tells whether the transfer happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Evaluate the opcode presented this cycle |
| opcode | input | 8 | Opcode byte |
| pcIn | input | PC_W | Program counter just past the opcode |
| disp | input | 8 | Signed relative displacement |
| target | input | PC_W | Absolute target operand |
| flags | input | 8 | Flag register |
| bIn | input | 8 | Current B register |
| hlIn | input | PC_W | Current HL pair |
| popData | input | PC_W | Value delivered by the stack on pop |
| pushAck | input | 1 | Stack accepted the push |
| popAck | input | 1 | Stack delivered the pop |
| ready | output | 1 | Idle and able to accept `start` |
| done | output | 1 | Result valid, one cycle |
| nextPc | output | PC_W | Next program counter |
| taken | output | 1 | Transfer happened |
| pushReq | output | 1 | Request to push `pushData` |
| pushData | output | PC_W | Return address to push |
| popReq | output | 1 | Request to pop a return address |
| bOut | output | 8 | Decremented B value |
| bWrite | output | 1 | Write strobe for `bOut` |

## Verification
The assertions assume the stack side acknowledges only while the matching request is raised, and that `popData` is valid at the acknowledging edge. The stimulus therefore raises `pushAck` or `popAck` only after seeing the corresponding request, and holds it for one cycle. The assertions also assume `start` may arrive at any time. A correct design must absorb a `start` that arrives mid-transaction, so the stimulus deliberately pulses `start` while a push is outstanding. The operands are sampled only at the accepting edge, so the bench changes them freely afterwards.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  localparam int FLAG_W   = 8;
  localparam int SIGN_POS = 7;
  localparam int ZERO_POS = 6;
  localparam int PAR_POS  = 2;
  localparam int CARRY_POS = 0;
  localparam int VEC_SHIFT = 3;

  typedef enum logic [3:0] {
    CL_NONE, CL_JR, CL_JRCC, CL_DJNZ, CL_JP, CL_JPCC, CL_JPHL,
    CL_CALL, CL_CALLCC, CL_RET, CL_RETCC, CL_RST
  } brClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFall;
    logic loadTaken;
    logic loadPop;
    logic loadRet;
    logic loadB;
  } dpStrobe_t;

  function automatic brClass_e classify(input logic [7:0] op);
    brClass_e c;
    c = CL_NONE;
    case (op)
      8'h10: c = CL_DJNZ;
      8'h18: c = CL_JR;
      8'hC3: c = CL_JP;
      8'hE9: c = CL_JPHL;
      8'hCD: c = CL_CALL;
      8'hC9: c = CL_RET;
      default: begin
        if (op[7:5] == 3'b001 && op[2:0] == 3'b000) c = CL_JRCC;
        else if (op[7:6] == 2'b11) begin
          case (op[2:0])
            3'b010:  c = CL_JPCC;
            3'b100:  c = CL_CALLCC;
            3'b000:  c = CL_RETCC;
            3'b111:  c = CL_RST;
            default: c = CL_NONE;
          endcase
        end
      end
    endcase
    return c;
  endfunction

  // condition index: bits 2:1 pick the flag, bit 0 is the required level
  function automatic logic condMet(input logic [2:0] cc, input logic [FLAG_W-1:0] f);
    logic [2:0] pos;
    case (cc[2:1])
      2'd0:    pos = 3'(ZERO_POS);
      2'd1:    pos = 3'(CARRY_POS);
      2'd2:    pos = 3'(PAR_POS);
      default: pos = 3'(SIGN_POS);
    endcase
    return f[pos] == cc[0];
  endfunction

endpackage

// File: rtl/nextpc_ctrl.sv
module nextpc_ctrl
  import nextpc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [FLAG_W-1:0] flags,
  input  logic [7:0]       bIn,
  input  logic             pushAck,
  input  logic             popAck,
  output dpStrobe_t        strobe,
  output brClass_e         opClass,
  output logic             ready,
  output logic             done,
  output logic             taken,
  output logic             pushReq,
  output logic             popReq
);

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_POP, S_DONE} state_e;

  state_e stateQ, stateD;
  logic   takenQ, takenD;
  logic   goTaken;

  assign opClass = classify(opcode);

  always_comb begin
    case (opClass)
      CL_JR, CL_JP, CL_JPHL, CL_CALL, CL_RET, CL_RST: goTaken = 1'b1;
      CL_JRCC:                         goTaken = condMet({1'b0, opcode[4:3]}, flags);
      CL_JPCC, CL_CALLCC, CL_RETCC:    goTaken = condMet(opcode[5:3], flags);
      CL_DJNZ:                         goTaken = (bIn != 8'd1);
      default:                         goTaken = 1'b0;
    endcase
  end

  always_comb begin
    stateD = stateQ;
    takenD = takenQ;
    strobe = '0;
    case (stateQ)
      S_IDLE: begin
        if (start) begin
          takenD       = goTaken;
          strobe.loadB = (opClass == CL_DJNZ);
          stateD       = S_DONE;
          if (goTaken) begin
            case (opClass)
              CL_CALL, CL_CALLCC, CL_RST: begin
                strobe.loadTaken = 1'b1;
                strobe.loadRet   = 1'b1;
                stateD           = S_PUSH;
              end
              CL_RET, CL_RETCC: stateD = S_POP;
              default:          strobe.loadTaken = 1'b1;
            endcase
          end else begin
            strobe.loadFall = 1'b1;
          end
        end
      end
      S_PUSH: if (pushAck) stateD = S_DONE;
      S_POP: begin
        if (popAck) begin
          strobe.loadPop = 1'b1;
          stateD         = S_DONE;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      takenQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      takenQ <= takenD;
    end
  end

  assign ready   = (stateQ == S_IDLE);
  assign done    = (stateQ == S_DONE);
  assign pushReq = (stateQ == S_PUSH);
  assign popReq  = (stateQ == S_POP);
  assign taken   = done & takenQ;

  p_push_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    pushReq && !pushAck |=> pushReq);
  p_pop_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    popReq && !popAck |=> popReq);
  p_req_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(pushReq && popReq));
  p_pop_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    popReq && popAck |=> done);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && ready);
  p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !pushReq && !popReq && !done);

endmodule

// File: rtl/nextpc_dp.sv
module nextpc_dp
  import nextpc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  brClass_e        opClass,
  input  logic [2:0]      vecIdx,
  input  logic [PC_W-1:0] pcIn,
  input  logic [7:0]      disp,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] hlIn,
  input  logic [7:0]      bIn,
  input  logic [PC_W-1:0] popData,
  output logic [PC_W-1:0] nextPc,
  output logic [PC_W-1:0] pushData,
  output logic [7:0]      bOut,
  output logic            bWrite
);

  localparam logic [PC_W-1:0] ONE = PC_W'(1);
  localparam logic [PC_W-1:0] TWO = PC_W'(2);

  logic [PC_W-1:0] pcNext1, pcNext2, relAddr, vecAddr;
  logic [PC_W-1:0] fallCalc, takenCalc, retCalc;

  assign pcNext1 = pcIn + ONE;
  assign pcNext2 = pcIn + TWO;
  assign relAddr = pcNext1 + {{(PC_W-8){disp[7]}}, disp};
  assign vecAddr = PC_W'(vecIdx) << VEC_SHIFT;

  always_comb begin
    case (opClass)
      CL_JR, CL_JRCC, CL_DJNZ:         fallCalc = pcNext1;
      CL_JP, CL_JPCC, CL_CALL, CL_CALLCC: fallCalc = pcNext2;
      default:                         fallCalc = pcIn;
    endcase
  end

  always_comb begin
    case (opClass)
      CL_JR, CL_JRCC, CL_DJNZ:         takenCalc = relAddr;
      CL_JP, CL_JPCC, CL_CALL, CL_CALLCC: takenCalc = target;
      CL_JPHL:                         takenCalc = hlIn;
      CL_RST:                          takenCalc = vecAddr;
      default:                         takenCalc = pcIn;
    endcase
  end

  assign retCalc = (opClass == CL_RST) ? pcIn : pcNext2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextPc   <= '0;
      pushData <= '0;
      bOut     <= '0;
      bWrite   <= 1'b0;
    end else begin
      if (strobe.loadFall)       nextPc <= fallCalc;
      else if (strobe.loadTaken) nextPc <= takenCalc;
      else if (strobe.loadPop)   nextPc <= popData;
      if (strobe.loadRet) pushData <= retCalc;
      if (strobe.loadB)   bOut <= bIn - 8'd1;
      bWrite <= strobe.loadB;
    end
  end

  p_vec_align_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTaken && opClass == CL_RST |=> nextPc[2:0] == 3'd0 && (nextPc >> 6) == '0);
  p_one_load_r12: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.loadFall, strobe.loadTaken, strobe.loadPop}) <= 1);

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [7:0]      opcode,
  input  logic [PC_W-1:0] pcIn,
  input  logic [7:0]      disp,
  input  logic [PC_W-1:0] target,
  input  logic [7:0]      flags,
  input  logic [7:0]      bIn,
  input  logic [PC_W-1:0] hlIn,
  input  logic [PC_W-1:0] popData,
  input  logic            pushAck,
  input  logic            popAck,
  output logic            ready,
  output logic            done,
  output logic [PC_W-1:0] nextPc,
  output logic            taken,
  output logic            pushReq,
  output logic [PC_W-1:0] pushData,
  output logic            popReq,
  output logic [7:0]      bOut,
  output logic            bWrite
);

  dpStrobe_t strobe;
  brClass_e  opClass;

  nextpc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .flags(flags),
    .bIn(bIn), .pushAck(pushAck), .popAck(popAck), .strobe(strobe),
    .opClass(opClass), .ready(ready), .done(done), .taken(taken),
    .pushReq(pushReq), .popReq(popReq)
  );

  nextpc_dp #(.PC_W(PC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opClass(opClass),
    .vecIdx(opcode[5:3]), .pcIn(pcIn), .disp(disp), .target(target),
    .hlIn(hlIn), .bIn(bIn), .popData(popData), .nextPc(nextPc),
    .pushData(pushData), .bOut(bOut), .bWrite(bWrite)
  );

  p_push_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    pushReq && !pushAck |=> $stable(pushData) && $stable(nextPc));
  p_bwrite_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    bWrite |-> done);

endmodule

// File: tb/nextpc_unit_test.sv
module nextpc_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0, disp = '0, flags = '0, bIn = '0;
  logic [15:0] pcIn = '0, target = '0;
  logic [15:0] hlIn = 16'h4321, popData = 16'hBEEF;
  logic        pushAck = 1'b0, popAck = 1'b0;
  logic        ready, done, taken, pushReq, popReq, bWrite;
  logic [15:0] nextPc, pushData;
  logic [7:0]  bOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nextpc_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .pcIn(pcIn),
    .disp(disp), .target(target), .flags(flags), .bIn(bIn), .hlIn(hlIn),
    .popData(popData), .pushAck(pushAck), .popAck(popAck), .ready(ready),
    .done(done), .nextPc(nextPc), .taken(taken), .pushReq(pushReq),
    .pushData(pushData), .popReq(popReq), .bOut(bOut), .bWrite(bWrite)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] pc;
    logic [7:0]  dsp;
    logic [15:0] tgt;
    logic [7:0]  flg;
    logic [7:0]  b;
    logic [15:0] expPc;
    logic        expTk;
    logic        expPush;
    logic [15:0] expPushData;
    logic        expPop;
    logic [7:0]  expB;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    // R2 unconditional relative
    '{8'h18,16'h1000,8'h05,16'h0000,8'h00,8'h00,16'h1006,1'b1,1'b0,16'h0000,1'b0,8'h00,4'd2},
    '{8'h18,16'h1000,8'hFE,16'h0000,8'h00,8'h00,16'h0FFF,1'b1,1'b0,16'h0000,1'b0,8'h00,4'd2},
    // R3 conditional relative
    '{8'h20,16'h2000,8'h10,16'h0000,8'h00,8'h00,16'h2011,1'b1,1'b0,16'h0000,1'b0,8'h00,4'd3},
    '{8'h20,16'h2000,8'h10,16'h0000,8'h40,8'h00,16'h2001,1'b0,1'b0,16'h0000,1'b0,8'h00,4'd3},
    '{8'h28,16'h2000,8'h10,16'h0000,8'h40,8'h00,16'h2011,1'b1,1'b0,16'h0000,1'b0,8'h00,4'd3},
    '{8'h38,16'h2000,8'h80,16'h0000,8'h01,8'h00,16'h1F81,1'b1,1'b0,16'h0000,1'b0,8'h00,4'd3},
    '{8'h30,16'h2000,8'h80,16'h0000,8'h01,8'h00,16'h2001,1'b0,1'b0,16'h0000,1'b0,8'h00,4'd3},
    // R4 decrement and branch
    '{8'h10,16'h3000,8'hF0,16'h0000,8'h00,8'h05,16'h2FF1,1'b1,1'b0,16'h0000,1'b0,8'h04,4'd4},
    '{8'h10,16'h3000,8'hF0,16'h0000,8'h00,8'h01,16'h3001,1'b0,1'b0,16'h0000,1'b0,8'h00,4'd4},
    '{8'h10,16'h3000,8'h02,16'h0000,8'h00,8'h00,16'h3003,1'b1,1'b0,16'h0000,1'b0,8'hFF,4'd4},
    // R5 absolute jumps
    '{8'hC2,16'h4000,8'h00,16'h1234,8'h00,8'h00,16'h1234,1'b1,1'b0,16'h0000,1'b0,8'h00,4'd5},
    '{8'hCA,16'h4000,8'h00,16'h1234,8'h00,8'h00,16'h4002,1'b0,1'b0,16'h0000,1'b0,8'h00,4'd5},
    '{8'hD2,16'h4000,8'h00,16'h1234,8'h01,8'h00,16'h4002,1'b0,1'b0,16'h0000,1'b0,8'h00,4'd5},
    '{8'hEA,16'h4000,8'h00,16'h1234,8'h04,8'h00,16'h1234,1'b1,1'b0,16'h0000,1'b0,8'h00,4'd5},
    '{8'hE2,16'h4000,8'h00,16'h1234,8'h04,8'h00,16'h4002,1'b0,1'b0,16'h0000,1'b0,8'h00,4'd5},
    '{8'hFA,16'h4000,8'h00,16'h1234,8'h80,8'h00,16'h1234,1'b1,1'b0,16'h0000,1'b0,8'h00,4'd5},
    '{8'hF2,16'h4000,8'h00,16'h1234,8'h80,8'h00,16'h4002,1'b0,1'b0,16'h0000,1'b0,8'h00,4'd5},
    '{8'hC3,16'h4000,8'h00,16'h1234,8'hFF,8'h00,16'h1234,1'b1,1'b0,16'h0000,1'b0,8'h00,4'd5},
    // R6 calls
    '{8'hCD,16'h5000,8'h00,16'h6789,8'h00,8'h00,16'h6789,1'b1,1'b1,16'h5002,1'b0,8'h00,4'd6},
    '{8'hDC,16'h5000,8'h00,16'h6789,8'h00,8'h00,16'h5002,1'b0,1'b0,16'h0000,1'b0,8'h00,4'd6},
    '{8'hFC,16'h5000,8'h00,16'h6789,8'h80,8'h00,16'h6789,1'b1,1'b1,16'h5002,1'b0,8'h00,4'd6},
    '{8'hE4,16'h5000,8'h00,16'h6789,8'h00,8'h00,16'h6789,1'b1,1'b1,16'h5002,1'b0,8'h00,4'd6},
    // R7 returns
    '{8'hC9,16'h7000,8'h00,16'h0000,8'h00,8'h00,16'hBEEF,1'b1,1'b0,16'h0000,1'b1,8'h00,4'd7},
    '{8'hC0,16'h7000,8'h00,16'h0000,8'h40,8'h00,16'h7000,1'b0,1'b0,16'h0000,1'b0,8'h00,4'd7},
    '{8'hF8,16'h7000,8'h00,16'h0000,8'h80,8'h00,16'hBEEF,1'b1,1'b0,16'h0000,1'b1,8'h00,4'd7},
    '{8'hD8,16'h7000,8'h00,16'h0000,8'h00,8'h00,16'h7000,1'b0,1'b0,16'h0000,1'b0,8'h00,4'd7},
    // R8 restarts
    '{8'hFF,16'h8000,8'h00,16'h0000,8'h00,8'h00,16'h0038,1'b1,1'b1,16'h8000,1'b0,8'h00,4'd8},
    '{8'hC7,16'h8000,8'h00,16'h0000,8'h00,8'h00,16'h0000,1'b1,1'b1,16'h8000,1'b0,8'h00,4'd8},
    '{8'hEF,16'h8000,8'h00,16'h0000,8'h00,8'h00,16'h0028,1'b1,1'b1,16'h8000,1'b0,8'h00,4'd8},
    // R9 jump through HL
    '{8'hE9,16'h8000,8'h00,16'h0000,8'h00,8'h00,16'h4321,1'b1,1'b0,16'h0000,1'b0,8'h00,4'd9},
    // R10 non-branch opcodes
    '{8'h00,16'h9000,8'h00,16'h0000,8'h00,8'h00,16'h9000,1'b0,1'b0,16'h0000,1'b0,8'h00,4'd10},
    '{8'h76,16'h9000,8'h00,16'h0000,8'hFF,8'h00,16'h9000,1'b0,1'b0,16'h0000,1'b0,8'h00,4'd10}
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(nextPc == 16'h0, "R1 nextPc", 32'(nextPc), 32'h0);
    chk(!done && !taken && !pushReq && !popReq && !bWrite, "R1 outputs low",
        32'({done, taken, pushReq, popReq, bWrite}), 32'h0);
    chk(ready, "R1 ready", 32'(ready), 32'h1);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      automatic string tag = $sformatf("R%0d vec%0d", v.rq, i);
      automatic bit sawPush = 0, sawPop = 0, gotDone = 0;
      automatic logic [15:0] seenPush = '0;
      automatic int waitN = 0;
      opcode = v.op; pcIn = v.pc; disp = v.dsp; target = v.tgt;
      flags = v.flg; bIn = v.b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      opcode = 8'h00; pcIn = 16'hDEAD; disp = 8'h55; target = 16'hCAFE; bIn = 8'h77;
      for (int c = 0; c < 20 && !gotDone; c++) begin
        pushAck = 1'b0;
        popAck  = 1'b0;
        if (done) begin
          gotDone = 1;
          chk(nextPc == v.expPc, {tag, " nextPc"}, 32'(nextPc), 32'(v.expPc));
          chk(taken == v.expTk, {tag, " taken R12"}, 32'(taken), 32'(v.expTk));
          chk(sawPush == v.expPush, {tag, " push"}, 32'(sawPush), 32'(v.expPush));
          chk(sawPop == v.expPop, {tag, " pop"}, 32'(sawPop), 32'(v.expPop));
          if (v.expPush)
            chk(seenPush == v.expPushData, {tag, " pushData"}, 32'(seenPush), 32'(v.expPushData));
          if (v.op == 8'h10)
            chk(bWrite && bOut == v.expB, {tag, " bOut"}, 32'({bWrite, bOut}), 32'({1'b1, v.expB}));
          else
            chk(!bWrite, {tag, " no bWrite"}, 32'(bWrite), 32'h0);
        end else if (pushReq || popReq) begin
          if (pushReq) begin
            if (sawPush)
              chk(pushData == seenPush, {tag, " pushData held R6"}, 32'(pushData), 32'(seenPush));
            sawPush = 1; seenPush = pushData;
          end
          if (popReq) sawPop = 1;
          waitN++;
          if (waitN >= 2) begin
            pushAck = pushReq;
            popAck  = popReq;
          end
        end
        @(negedge clk);
      end
      chk(gotDone, {tag, " completion"}, 32'(gotDone), 32'h1);
      chk(ready && !done, {tag, " back to ready R12"}, 32'({ready, done}), 32'h2);
    end

    // R11: start while a push is outstanding is ignored
    opcode = 8'hCD; pcIn = 16'hA000; target = 16'h1111; flags = 8'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!ready && pushReq, "R11 busy after start", 32'({ready, pushReq}), 32'h1);
    opcode = 8'h18; pcIn = 16'h0000; disp = 8'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(pushReq && pushData == 16'hA002, "R11 push unaffected",
        32'({pushReq, pushData}), 32'h1A002);
    pushAck = 1'b1;
    @(negedge clk);
    pushAck = 1'b0;
    chk(done && nextPc == 16'h1111, "R11 result unaffected", 32'({done, nextPc}), 32'h11111);
    @(negedge clk);
    chk(ready && !done, "R11 ready after done", 32'({ready, done}), 32'h2);
    @(negedge clk);
    chk(!done && nextPc == 16'h1111, "R11 no second result", 32'({done, nextPc}), 32'h01111);

    summary();
    $finish;
  end

endmodule